// File: doc/BRIEF.md
# Serial Four-Point FFT Engine

This block computes a forward four-point discrete Fourier transform on a stream of complex samples that arrive one per clock. Instead of building four butterflies side by side, it keeps three delay registers on the input and reuses one first-stage butterfly on two consecutive steps. A single second-stage butterfly runs on the two steps after that. A free-running two-bit step counter drives a small controller, and the controller sends the datapath a struct of per-step strobes. These strobes set which operands the butterflies take, which twiddle the first stage applies, and which of three candidate values goes to the output register.

Frames are back to back, and the first frame after reset begins on the first clock after reset is released. The four bins of each frame come out on four consecutive clocks in bin order. Each bin has a valid flag. The output words are two bits wider than the input so that full-scale inputs never overflow.

Top module: `fft4s_serial`

## Requirements
- R1: While `rst` is high on a rising edge, the step counter returns to zero, and `outValid`, `outRe` and `outIm` go to zero. `outValid` then stays low for the first five clock edges after `rst` falls.
- R2: The sample captured on edge e after reset (e counted from 0) is x(e mod 4) of frame e/4. A reset in the middle of a frame discards the partial frame and realigns frame boundaries to the release of reset.
- R3: For each frame, bin k equals the sum over n of x(n)·W^(nk) with W = −j. So X(0)=x0+x1+x2+x3, X(1)=(x0−x2)−j(x1−x3), X(2)=x0−x1+x2−x3 and X(3)=(x0−x2)+j(x1−x3). The result is exact two's complement with no scaling.
- R4: Bins leave in the order X(0), X(1), X(2), X(3) on consecutive clocks. X(0) is on the outputs in the third clock cycle after the cycle in which x(3) is presented, so it is visible after edge 4f+5 for frame f.
- R5: `outValid` is high in every cycle that carries a bin, once per bin. Under a continuous stream it stays high from the first bin onward.
- R6: Outputs are DW+2 bits, signed. All-maximum, all-minimum and alternating full-scale inputs give exact results with no wraparound.
- R7: Consecutive frames are transformed independently, with no gap cycles between frames and no effect of one frame on the next.
- R8: The step counter wraps from 3 to 0 every four clocks. The first-stage butterfly works on steps 3 and 0: the −j rotation is applied on the second of these steps only, and the second-stage twiddle is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inRe | input | DW | Real part of the input sample, signed |
| inIm | input | DW | Imaginary part of the input sample, signed |
| outRe | output | DW+2 | Real part of the current bin, signed |
| outIm | output | DW+2 | Imaginary part of the current bin, signed |
| outValid | output | 1 | High while a bin is on the outputs |

## Verification
The bench builds the engine with its default data width of 16 bits per component, so the output is 18 bits. At this width the bench can drive exact full-scale extremes: all 32767, all −32768, and alternating signs. These show whether the guard bits added at each stage absorb the worst-case growth in both butterflies and in the −j swap-and-negate. A stream of several frames, a ramp, impulses placed at different indices, and a reset in the middle of a frame cover the twiddle order, the rotation of the output mux through its three sources, and the realignment of frames after reset.

// File: rtl/fft4s_pkg.sv
package fft4s_pkg;
  localparam int NPT = 4;
  localparam int SW  = $clog2(NPT);

  // Output mux sources.
  localparam logic [1:0] SEL_BFLY  = 2'd0;
  localparam logic [1:0] SEL_HOLD0 = 2'd1;
  localparam logic [1:0] SEL_HOLD1 = 2'd2;

  typedef struct packed {
    logic       s1En;   // first-stage butterfly result is captured
    logic       s1Rot;  // apply -j to the first-stage difference, store in slot B
    logic       s2En;   // second-stage butterfly active, hold taps shift
    logic       s2Dif;  // second stage takes the difference slots
    logic [1:0] outSel; // output mux source
    logic       outVld; // the value being loaded is a real bin
  } ctrl_t;
endpackage

// File: rtl/fft4s_ctrl.sv
module fft4s_ctrl
  import fft4s_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output ctrl_t ctl
);
  logic [SW-1:0] step;
  logic [1:0]    fill;

  localparam logic [SW-1:0] LAST = SW'(NPT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
      fill <= '0;
    end else begin
      step <= step + SW'(1);
      if (step == LAST && fill != 2'd2) fill <= fill + 2'd1;
    end
  end

  always_comb begin
    ctl = '0;
    case (step)
      SW'(3): begin ctl.s1En = 1'b1; ctl.s1Rot = 1'b0; ctl.outSel = SEL_HOLD1; end
      SW'(0): begin ctl.s1En = 1'b1; ctl.s1Rot = 1'b1; ctl.outSel = SEL_HOLD0; end
      SW'(1): begin ctl.s2En = 1'b1; ctl.s2Dif = 1'b0; ctl.outSel = SEL_BFLY;  end
      default: begin ctl.s2En = 1'b1; ctl.s2Dif = 1'b1; ctl.outSel = SEL_BFLY; end
    endcase
    // The bin loaded on step 0 belongs to a frame that finished two frame-ends ago.
    ctl.outVld = (step == SW'(0)) ? (fill == 2'd2) : (fill != 2'd0);
  end

  assert_step_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (step == LAST) |=> (step == SW'(0)));

  assert_twiddle_order_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl.s1En && !ctl.s1Rot) |=> (ctl.s1En && ctl.s1Rot));

  assert_fill_monotonic_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fill >= $past(fill)));
endmodule

// File: rtl/fft4s_dp.sv
module fft4s_dp
  import fft4s_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrl_t                ctl,
  input  logic signed [DW-1:0] inRe,
  input  logic signed [DW-1:0] inIm,
  output logic signed [DW+1:0] outRe,
  output logic signed [DW+1:0] outIm,
  output logic                 outValid
);
  localparam int W1    = DW + 1;
  localparam int W2    = DW + 2;
  localparam int NTAP  = NPT - 1;
  localparam int NHOLD = 2;

  // Input delay taps: tap[0] is the newest sample.
  logic signed [DW-1:0] tapRe [NTAP];
  logic signed [DW-1:0] tapIm [NTAP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAP; i++) begin tapRe[i] <= '0; tapIm[i] <= '0; end
    end else begin
      tapRe[0] <= inRe;
      tapIm[0] <= inIm;
      for (int i = 1; i < NTAP; i++) begin
        tapRe[i] <= tapRe[i-1];
        tapIm[i] <= tapIm[i-1];
      end
    end
  end

  // First stage: pairs sample n with sample n+2 (taps two apart).
  logic signed [W1-1:0] s1SumRe, s1SumIm, s1DifRe, s1DifIm, s1RotRe, s1RotIm;

  always_comb begin
    s1SumRe = W1'(tapRe[NTAP-1]) + W1'(tapRe[0]);
    s1SumIm = W1'(tapIm[NTAP-1]) + W1'(tapIm[0]);
    s1DifRe = W1'(tapRe[NTAP-1]) - W1'(tapRe[0]);
    s1DifIm = W1'(tapIm[NTAP-1]) - W1'(tapIm[0]);
    if (ctl.s1Rot) begin
      // Multiply by -j: (re, im) -> (im, -re).
      s1RotRe = s1DifIm;
      s1RotIm = -s1DifRe;
    end else begin
      s1RotRe = s1DifRe;
      s1RotIm = s1DifIm;
    end
  end

  // Stage-one result slots: A from the even pair, B from the odd pair.
  logic signed [W1-1:0] aSRe, aSIm, aDRe, aDIm, bSRe, bSIm, bDRe, bDIm;

  always_ff @(posedge clk) begin
    if (rst) begin
      aSRe <= '0; aSIm <= '0; aDRe <= '0; aDIm <= '0;
      bSRe <= '0; bSIm <= '0; bDRe <= '0; bDIm <= '0;
    end else if (ctl.s1En) begin
      if (ctl.s1Rot) begin
        bSRe <= s1SumRe; bSIm <= s1SumIm; bDRe <= s1RotRe; bDIm <= s1RotIm;
      end else begin
        aSRe <= s1SumRe; aSIm <= s1SumIm; aDRe <= s1RotRe; aDIm <= s1RotIm;
      end
    end
  end

  // Second stage: twiddle is always 1, so the multiplier is a pass-through.
  logic signed [W1-1:0] opARe, opAIm, opBRe, opBIm;
  logic signed [W2-1:0] bfSumRe, bfSumIm, bfDifRe, bfDifIm;

  always_comb begin
    opARe = ctl.s2Dif ? aDRe : aSRe;
    opAIm = ctl.s2Dif ? aDIm : aSIm;
    opBRe = ctl.s2Dif ? bDRe : bSRe;
    opBIm = ctl.s2Dif ? bDIm : bSIm;
    bfSumRe = W2'(opARe) + W2'(opBRe);
    bfSumIm = W2'(opAIm) + W2'(opBIm);
    bfDifRe = W2'(opARe) - W2'(opBRe);
    bfDifIm = W2'(opAIm) - W2'(opBIm);
  end

  // Hold taps carry the difference outputs until their output slot comes.
  logic signed [W2-1:0] holdRe [NHOLD];
  logic signed [W2-1:0] holdIm [NHOLD];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NHOLD; i++) begin holdRe[i] <= '0; holdIm[i] <= '0; end
    end else if (ctl.s2En) begin
      holdRe[0] <= bfDifRe;
      holdIm[0] <= bfDifIm;
      for (int i = 1; i < NHOLD; i++) begin
        holdRe[i] <= holdRe[i-1];
        holdIm[i] <= holdIm[i-1];
      end
    end
  end

  // Three-way output mux into the output register.
  logic signed [W2-1:0] muxRe, muxIm;

  always_comb begin
    case (ctl.outSel)
      SEL_HOLD0: begin muxRe = holdRe[0]; muxIm = holdIm[0]; end
      SEL_HOLD1: begin muxRe = holdRe[1]; muxIm = holdIm[1]; end
      default:   begin muxRe = bfSumRe;   muxIm = bfSumIm;   end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outRe    <= '0;
      outIm    <= '0;
      outValid <= 1'b0;
    end else begin
      outRe    <= muxRe;
      outIm    <= muxIm;
      outValid <= ctl.outVld;
    end
  end

  assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    outValid |=> outValid);

  assert_sel_range_R4: assert property (@(posedge clk) disable iff (rst)
    ctl.outSel != 2'd3);

  assert_stages_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(ctl.s1En && ctl.s2En));
endmodule

// File: rtl/fft4s_serial.sv
module fft4s_serial
  import fft4s_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] inRe,
  input  logic signed [DW-1:0] inIm,
  output logic signed [DW+1:0] outRe,
  output logic signed [DW+1:0] outIm,
  output logic                 outValid
);
  ctrl_t ctl;

  fft4s_ctrl u_ctrl (
    .clk (clk),
    .rst (rst),
    .ctl (ctl)
  );

  fft4s_dp #(.DW(DW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .inRe     (inRe),
    .inIm     (inIm),
    .outRe    (outRe),
    .outIm    (outIm),
    .outValid (outValid)
  );
endmodule

// File: tb/sim_fft4s_serial.sv
module sim_fft4s_serial;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int OW = DW + 2;
  localparam int MAXS = 64;

  logic clk = 1'b0;
  logic rst;
  logic signed [DW-1:0] inRe, inIm;
  logic signed [OW-1:0] outRe, outIm;
  logic outValid;

  int nVec = 0;
  int nBad = 0;
  int sRe [MAXS];
  int sIm [MAXS];

  fft4s_serial #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .inRe(inRe), .inIm(inIm),
    .outRe(outRe), .outIm(outIm), .outValid(outValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference bin k of frame f, computed straight from the DFT sum.
  task automatic refBin(input int f, input int k, output int xr, output int xi);
    int wr, wi;
    xr = 0; xi = 0;
    for (int n = 0; n < 4; n++) begin
      case ((n * k) % 4)
        0: begin wr = 1;  wi = 0;  end
        1: begin wr = 0;  wi = -1; end
        2: begin wr = -1; wi = 0;  end
        default: begin wr = 0; wi = 1; end
      endcase
      xr += sRe[4*f+n] * wr - sIm[4*f+n] * wi;
      xi += sRe[4*f+n] * wi + sIm[4*f+n] * wr;
    end
  endtask

  task automatic doReset();
    rst = 1'b1; inRe = '0; inIm = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "valid after reset", int'(outValid), 0);
    chk("R1", "outRe after reset", int'(outRe), 0);
  endtask

  // Streams nFr frames starting at edge 0 after reset and checks every output cycle.
  task automatic stream(input int nFr, input string req);
    int xr, xi, f, k;
    for (int e = 0; e <= 4*nFr + 4; e++) begin
      inRe = (e < 4*nFr) ? DW'(sRe[e]) : '0;
      inIm = (e < 4*nFr) ? DW'(sIm[e]) : '0;
      @(posedge clk);
      @(negedge clk);
      if (e < 5) begin
        chk("R1", "valid low before first bin", int'(outValid), 0);
      end else begin
        f = (e - 5) / 4;
        k = (e - 5) % 4;
        if (f < nFr) begin
          refBin(f, k, xr, xi);
          chk("R5", $sformatf("valid f%0d k%0d", f, k), int'(outValid), 1);
          chk(req, $sformatf("R4 re f%0d k%0d", f, k), int'(outRe), xr);
          chk(req, $sformatf("R4 im f%0d k%0d", f, k), int'(outIm), xi);
        end
      end
    end
  endtask

  task automatic testRamp();
    for (int n = 0; n < 4; n++) begin sRe[n] = n; sIm[n] = n; end
    doReset();
    stream(1, "R3");
  endtask

  task automatic testImpulses();
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 4; n++) begin
        sRe[4*p+n] = (n == p) ? 100 + p : 0;
        sIm[4*p+n] = (n == p) ? -7 * p : 0;
      end
    end
    doReset();
    stream(4, "R3");
  endtask

  task automatic testFullScale();
    for (int n = 0; n < 4; n++) begin
      sRe[n] = 32767;  sIm[n] = -32768;
      sRe[4+n] = -32768; sIm[4+n] = 32767;
      sRe[8+n] = (n % 2 == 0) ? 32767 : -32768;
      sIm[8+n] = (n % 2 == 0) ? -32768 : 32767;
      sRe[12+n] = (n < 2) ? -32768 : 32767;
      sIm[12+n] = (n < 2) ? 32767 : -32768;
    end
    doReset();
    stream(4, "R6");
  endtask

  task automatic testStream();
    for (int n = 0; n < 32; n++) begin
      sRe[n] = ((n * 7919 + 13) * 31) % 65536 - 32768;
      sIm[n] = ((n * 104729 + 5) * 17) % 65536 - 32768;
    end
    doReset();
    stream(8, "R7");
  endtask

  task automatic testMidReset();
    for (int n = 0; n < 4; n++) begin sRe[n] = 50 * n - 3; sIm[n] = 9 - 4 * n; end
    doReset();
    inRe = 16'sd1234; inIm = -16'sd999;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    doReset();
    stream(1, "R2");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    rst = 1'b1; inRe = '0; inIm = '0;
    testRamp();
    testImpulses();
    testFullScale();
    testStream();
    testMidReset();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule